// File: doc/BRIEF.md
# Debug halt peripheral freeze controller

This block decides how a handful of on-chip peripherals behave while the processor sits at a breakpoint. A core-halted input, combined with per-peripheral freeze bits, gates the count enable of a timer and a watchdog counter, suspends the update of a CAN receive register and an SMBus timeout counter, and forces a timer's complementary output pair into the disabled state. When the core is running, the freeze bits do nothing and every peripheral runs normally.

Two 32-bit registers, reached through a simple word-addressed write/read port, hold the configuration. One carries low-power debug controls and trace pin settings that are passed straight to outputs. The other carries the freeze bits. Both registers are cleared only by power-on reset, so a debugger can set them up while the system is held in reset and they survive a system reset pulse. An 8-bit timer counter (with a compare-based complementary output pair) and an 8-bit watchdog counter are included so that the gating can be observed at the ports.

Top module: `dbgfrz_top`

## Requirements
- R1: Both registers are cleared to 0x00000000 by por_n low only; a sys_rst_n pulse leaves their contents unchanged, and a full write made while sys_rst_n is low takes effect.
- R2: A write takes effect only when reg_wr is high and all four bits of reg_be are 1; any write with a byte enable of 0 leaves both registers unchanged.
- R3: Word address 0 is the debug configuration register: bit 0 drives dbg_sleep, bit 1 dbg_stop, bit 2 dbg_standby, bit 5 trace_pin_en, bits 7:6 trace_mode; every other bit reads 0 and ignores writes.
- R4: Word address 1 is the freeze register: bit 0 freezes the timer, bit 1 the watchdog, bit 2 the CAN receive update, bit 3 the SMBus timeout; other bits read 0. Addresses 2 and 3 read 0 and accept no writes.
- R5: With the timer freeze bit at 1, tim_cnt holds its value on every clock edge at which core_halted is high; with it at 0 the timer keeps counting through a halt. After the halt ends counting resumes with no lost or extra count.
- R6: The watchdog counter follows the same rule as R5 under its own freeze bit, independently of the timer.
- R7: When the core is halted with the timer freeze bit set, tim_out_p and tim_out_n are both 0 from the first clock edge after core_halted rises until the first edge after it falls; otherwise tim_out_p is 1 when tim_cnt < 128 and tim_out_n is its complement.
- R8: can_rx_hold is 1 exactly while core_halted is high and the CAN freeze bit is set.
- R9: smb_to_hold is 1 exactly while core_halted is high and the SMBus freeze bit is set.
- R10: While core_halted is low, the freeze bits have no effect: both counters advance, both hold outputs are 0 and the output pair stays complementary.
- R11: sys_rst_n low clears both counters to 0; otherwise an enabled counter increments by one per clock and wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears the registers |
| sys_rst_n | input | 1 | System reset, active low, clears counters and output-disable state |
| core_halted | input | 1 | High while the processor is halted in debug |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Word address of the register |
| reg_be | input | 4 | Byte enables; all four needed for a write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| dbg_sleep | output | 1 | Debug kept alive in sleep |
| dbg_stop | output | 1 | Debug kept alive in stop |
| dbg_standby | output | 1 | Debug kept alive in standby |
| trace_pin_en | output | 1 | Trace pins enabled |
| trace_mode | output | 2 | Trace pin mode |
| tim_cnt | output | 8 | Timer counter value |
| wdg_cnt | output | 8 | Watchdog counter value |
| tim_out_p | output | 1 | Timer output, high while tim_cnt < 128 |
| tim_out_n | output | 1 | Complementary timer output |
| can_rx_hold | output | 1 | Blocks CAN receive register update |
| smb_to_hold | output | 1 | Suspends the SMBus timeout counter |

## Verification
The hardest situation to reach is the interplay of the two resets: a register write issued while sys_rst_n is held low, followed by release, must keep the written value while the counters restart from zero. The bench holds sys_rst_n low across a full write, reads the register back through the port both during and after the pulse, and then measures the counters' restart. The halt boundaries are probed by changing core_halted between edges and sampling the output pair both before and after the next edge, so the single edge of latency in the output disable is seen on entry and on exit.

// File: rtl/dbgfrz_pkg.sv
package dbgfrz_pkg;

  localparam int unsigned REG_W = 32;
  localparam int unsigned BE_W  = REG_W / 8;

  // configuration register fields
  localparam int unsigned CB_SLEEP   = 0;
  localparam int unsigned CB_STOP    = 1;
  localparam int unsigned CB_STANDBY = 2;
  localparam int unsigned CB_TRC_EN  = 5;
  localparam int unsigned CB_TRC_LO  = 6;
  localparam logic [REG_W-1:0] CFG_MASK = 32'h0000_00E7;

  // freeze register fields
  localparam int unsigned FB_TIM = 0;
  localparam int unsigned FB_WDG = 1;
  localparam int unsigned FB_CAN = 2;
  localparam int unsigned FB_I2C = 3;
  localparam logic [REG_W-1:0] FRZ_MASK = 32'h0000_000F;

  typedef struct packed {
    logic       sleep;
    logic       stop;
    logic       standby;
    logic       trc_en;
    logic [1:0] trc_mode;
  } lp_cfg_t;

  typedef struct packed {
    logic tim;
    logic wdg;
    logic can;
    logic i2c;
  } frz_t;

  function automatic logic full_word(input logic [BE_W-1:0] be);
    return &be;
  endfunction

  function automatic logic hold_active(input logic halted, input logic frz_bit);
    return halted & frz_bit;
  endfunction

endpackage

// File: rtl/dbgfrz_regs.sv
module dbgfrz_regs
  import dbgfrz_pkg::*;
#(
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned CFG_IDX = 0,
  parameter int unsigned FRZ_IDX = 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output lp_cfg_t           cfg_o,
  output frz_t              frz_o
);

  logic [REG_W-1:0] cfg_q;
  logic [REG_W-1:0] frz_q;
  logic             full_wr;
  logic             cfg_we;
  logic             frz_we;

  assign full_wr = wr_en && full_word(be);
  assign cfg_we  = full_wr && (addr == ADDR_W'(CFG_IDX));
  assign frz_we  = full_wr && (addr == ADDR_W'(FRZ_IDX));

  // power-on reset only; system reset never touches these
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q <= '0;
      frz_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= wdata & CFG_MASK;
      if (frz_we) frz_q <= wdata & FRZ_MASK;
    end
  end

  always_comb begin
    if (addr == ADDR_W'(CFG_IDX))      rdata = cfg_q;
    else if (addr == ADDR_W'(FRZ_IDX)) rdata = frz_q;
    else                               rdata = '0;
  end

  always_comb begin
    cfg_o.sleep    = cfg_q[CB_SLEEP];
    cfg_o.stop     = cfg_q[CB_STOP];
    cfg_o.standby  = cfg_q[CB_STANDBY];
    cfg_o.trc_en   = cfg_q[CB_TRC_EN];
    cfg_o.trc_mode = cfg_q[CB_TRC_LO +: 2];
    frz_o.tim      = frz_q[FB_TIM];
    frz_o.wdg      = frz_q[FB_WDG];
    frz_o.can      = frz_q[FB_CAN];
    frz_o.i2c      = frz_q[FB_I2C];
  end

  // R2
  partial_wr_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !(&be)) |=> ($stable(cfg_q) && $stable(frz_q)));

  // R3
  cfg_store_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && (&be) && addr == ADDR_W'(CFG_IDX)) |=> (cfg_q == ($past(wdata) & CFG_MASK)));

  // R4
  frz_store_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && (&be) && addr == ADDR_W'(FRZ_IDX)) |=> (frz_q == ($past(wdata) & FRZ_MASK)));

endmodule

// File: rtl/dbgfrz_gate.sv
module dbgfrz_gate
  import dbgfrz_pkg::*;
(
  input  logic clk,
  input  logic sys_rst_n,
  input  logic core_halted,
  input  frz_t frz,
  output logic tim_en,
  output logic wdg_en,
  output logic can_hold,
  output logic smb_hold,
  output logic cmp_off
);

  logic tim_frozen;
  logic wdg_frozen;

  assign tim_frozen = hold_active(core_halted, frz.tim);
  assign wdg_frozen = hold_active(core_halted, frz.wdg);
  assign tim_en     = !tim_frozen;
  assign wdg_en     = !wdg_frozen;
  assign can_hold   = hold_active(core_halted, frz.can);
  assign smb_hold   = hold_active(core_halted, frz.i2c);

  // registered so the output pair changes only on a clock edge
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) cmp_off <= 1'b0;
    else            cmp_off <= tim_frozen;
  end

  // R10
  running_no_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !core_halted |-> (tim_en && wdg_en && !can_hold && !smb_hold));

  // R7
  off_enter_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (core_halted && frz.tim) |=> cmp_off);

  // R7
  off_leave_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !core_halted |=> !cmp_off);

endmodule

// File: rtl/dbgfrz_counter.sv
module dbgfrz_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v, input logic go);
    return go ? v + CNT_W'(1) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= step(cnt, en);
  end

  // R5
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));

  // R11
  step_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

endmodule

// File: rtl/dbgfrz_top.sv
module dbgfrz_top
  import dbgfrz_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DUTY  = 128
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic        core_halted,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        dbg_sleep,
  output logic        dbg_stop,
  output logic        dbg_standby,
  output logic        trace_pin_en,
  output logic [1:0]  trace_mode,
  output logic [7:0]  tim_cnt,
  output logic [7:0]  wdg_cnt,
  output logic        tim_out_p,
  output logic        tim_out_n,
  output logic        can_rx_hold,
  output logic        smb_to_hold
);

  localparam int unsigned NUM_CNT = 2;
  localparam int unsigned TIM_IX  = 0;
  localparam int unsigned WDG_IX  = 1;

  lp_cfg_t            cfg;
  frz_t               frz;
  logic [NUM_CNT-1:0] cnt_en;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];
  logic               cmp_off;
  logic               pwm_hi;

  dbgfrz_regs #(.ADDR_W(2)) u_regs (
    .clk   (clk),
    .por_n (por_n),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .be    (reg_be),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg_o (cfg),
    .frz_o (frz)
  );

  dbgfrz_gate u_gate (
    .clk         (clk),
    .sys_rst_n   (sys_rst_n),
    .core_halted (core_halted),
    .frz         (frz),
    .tim_en      (cnt_en[TIM_IX]),
    .wdg_en      (cnt_en[WDG_IX]),
    .can_hold    (can_rx_hold),
    .smb_hold    (smb_to_hold),
    .cmp_off     (cmp_off)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    dbgfrz_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .en    (cnt_en[g]),
      .cnt   (cnt_val[g])
    );
  end

  assign pwm_hi       = cnt_val[TIM_IX] < CNT_W'(DUTY);
  assign tim_out_p    = pwm_hi & ~cmp_off;
  assign tim_out_n    = ~pwm_hi & ~cmp_off;
  assign tim_cnt      = 8'(cnt_val[TIM_IX]);
  assign wdg_cnt      = 8'(cnt_val[WDG_IX]);

  assign dbg_sleep    = cfg.sleep;
  assign dbg_stop     = cfg.stop;
  assign dbg_standby  = cfg.standby;
  assign trace_pin_en = cfg.trc_en;
  assign trace_mode   = cfg.trc_mode;

  // R5
  tim_frozen_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
    (core_halted && frz.tim) |=> $stable(tim_cnt));

  // R6
  wdg_frozen_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
    (core_halted && frz.wdg) |=> $stable(wdg_cnt));

  // R7
  comp_pair_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
    !cmp_off |-> (tim_out_p ^ tim_out_n));

endmodule

// File: tb/test_dbgfrz_top.sv
module test_dbgfrz_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        por_n, sys_rst_n, core_halted, reg_wr;
  logic [1:0]  reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic        dbg_sleep, dbg_stop, dbg_standby, trace_pin_en;
  logic [1:0]  trace_mode;
  logic [7:0]  tim_cnt, wdg_cnt;
  logic        tim_out_p, tim_out_n, can_rx_hold, smb_to_hold;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  dbgfrz_top i_dbgfrz_top (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .core_halted(core_halted),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dbg_sleep(dbg_sleep), .dbg_stop(dbg_stop),
    .dbg_standby(dbg_standby), .trace_pin_en(trace_pin_en), .trace_mode(trace_mode),
    .tim_cnt(tim_cnt), .wdg_cnt(wdg_cnt), .tim_out_p(tim_out_p), .tim_out_n(tim_out_n),
    .can_rx_hold(can_rx_hold), .smb_to_hold(smb_to_hold)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // expected output pair when not disabled: high half of the count range drives n
  function automatic logic [1:0] pair_of(input logic [7:0] c);
    return (c[7] == 1'b0) ? 2'b10 : 2'b01;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); chk("R1 cfg after por", d, 32'h0);
    rd(2'd1, d); chk("R1 frz after por", d, 32'h0);
    chk("R11 tim in reset", tim_cnt, 8'h0);
    chk("R11 wdg in reset", wdg_cnt, 8'h0);
    chk("R7 pair in reset", {tim_out_p, tim_out_n}, 2'b10);
  endtask

  task automatic t_cfg_layout;
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF, 4'hF);
    rd(2'd0, d); chk("R3 reserved read zero", d, 32'h0000_00E7);
    wr(2'd0, 32'h0000_00A5, 4'hF);
    rd(2'd0, d); chk("R3 cfg readback", d, 32'h0000_00A5);
    chk("R3 field outputs", {dbg_sleep, dbg_stop, dbg_standby, trace_pin_en, trace_mode},
        {1'b1, 1'b0, 1'b1, 1'b1, 2'b10});
  endtask

  task automatic t_partial;
    logic [31:0] d;
    wr(2'd0, 32'h0, 4'h1);
    rd(2'd0, d); chk("R2 be=1 ignored", d, 32'h0000_00A5);
    wr(2'd0, 32'h0, 4'hE);
    rd(2'd0, d); chk("R2 be=E ignored", d, 32'h0000_00A5);
    wr(2'd1, 32'hF, 4'h7);
    rd(2'd1, d); chk("R2 frz be=7 ignored", d, 32'h0);
  endtask

  task automatic t_frz_layout;
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF, 4'hF);
    rd(2'd1, d); chk("R4 frz reserved zero", d, 32'h0000_000F);
    wr(2'd2, 32'hFFFF_FFFF, 4'hF);
    rd(2'd2, d); chk("R4 addr2 reads zero", d, 32'h0);
    rd(2'd0, d); chk("R4 addr2 write no alias", d, 32'h0000_00A5);
  endtask

  task automatic t_idle;
    logic [7:0] t0, w0;
    core_halted = 1'b0;
    @(negedge clk);
    t0 = tim_cnt; w0 = wdg_cnt;
    idle(5);
    chk("R10 tim runs", tim_cnt, 8'(t0 + 8'd5));
    chk("R10 wdg runs", wdg_cnt, 8'(w0 + 8'd5));
    chk("R10 holds low", {can_rx_hold, smb_to_hold}, 2'b00);
    chk("R10 pair live", {tim_out_p, tim_out_n}, pair_of(tim_cnt));
  endtask

  task automatic t_timer;
    logic [7:0] t0, w0;
    wr(2'd1, 32'h1, 4'hF);
    @(negedge clk);
    t0 = tim_cnt; w0 = wdg_cnt;
    core_halted = 1'b1;
    #1;
    chk("R7 pair before edge", {tim_out_p, tim_out_n}, pair_of(t0));
    idle(4);
    chk("R5 tim frozen", tim_cnt, t0);
    chk("R6 wdg not frozen", wdg_cnt, 8'(w0 + 8'd4));
    chk("R7 pair off", {tim_out_p, tim_out_n}, 2'b00);
    core_halted = 1'b0;
    #1;
    chk("R7 off until edge", {tim_out_p, tim_out_n}, 2'b00);
    idle(3);
    chk("R5 resume no loss", tim_cnt, 8'(t0 + 8'd3));
    chk("R7 pair back", {tim_out_p, tim_out_n}, pair_of(tim_cnt));
    // freeze bit clear: timer runs through halt
    wr(2'd1, 32'h0, 4'hF);
    @(negedge clk);
    t0 = tim_cnt;
    core_halted = 1'b1;
    idle(5);
    chk("R5 tim runs unfrozen", tim_cnt, 8'(t0 + 8'd5));
    chk("R7 pair live unfrozen", {tim_out_p, tim_out_n}, pair_of(tim_cnt));
    core_halted = 1'b0;
  endtask

  task automatic t_wdg;
    logic [7:0] t0, w0;
    wr(2'd1, 32'h2, 4'hF);
    @(negedge clk);
    t0 = tim_cnt; w0 = wdg_cnt;
    core_halted = 1'b1;
    idle(6);
    chk("R6 wdg frozen", wdg_cnt, w0);
    chk("R6 tim independent", tim_cnt, 8'(t0 + 8'd6));
    core_halted = 1'b0;
    idle(2);
    chk("R6 wdg resume", wdg_cnt, 8'(w0 + 8'd2));
  endtask

  task automatic t_holds;
    wr(2'd1, 32'hC, 4'hF);
    core_halted = 1'b0; #1;
    chk("R8 R9 no halt", {can_rx_hold, smb_to_hold}, 2'b00);
    core_halted = 1'b1; #1;
    chk("R8 R9 both", {can_rx_hold, smb_to_hold}, 2'b11);
    wr(2'd1, 32'h4, 4'hF); #1;
    chk("R8 can only", {can_rx_hold, smb_to_hold}, 2'b10);
    wr(2'd1, 32'h8, 4'hF); #1;
    chk("R9 smb only", {can_rx_hold, smb_to_hold}, 2'b01);
    core_halted = 1'b0; #1;
    chk("R9 released", smb_to_hold, 1'b0);
  endtask

  task automatic t_sysrst;
    logic [31:0] d;
    wr(2'd1, 32'hF, 4'hF);
    @(negedge clk);
    sys_rst_n = 1'b0;
    idle(1);
    chk("R11 tim cleared", tim_cnt, 8'h0);
    chk("R11 wdg cleared", wdg_cnt, 8'h0);
    wr(2'd0, 32'h0000_0042, 4'hF);
    rd(2'd0, d); chk("R1 write in sys reset", d, 32'h0000_0042);
    rd(2'd1, d); chk("R1 frz kept in sys reset", d, 32'h0000_000F);
    sys_rst_n = 1'b1;
    idle(3);
    chk("R11 restart count", tim_cnt, 8'd3);
    rd(2'd0, d); chk("R1 cfg after sys reset", d, 32'h0000_0042);
    chk("R3 stop and mode", {dbg_stop, trace_mode}, {1'b1, 2'b01});
  endtask

  task automatic t_por;
    logic [31:0] d;
    @(negedge clk);
    por_n = 1'b0;
    rd(2'd0, d); chk("R1 por clears cfg", d, 32'h0);
    rd(2'd1, d); chk("R1 por clears frz", d, 32'h0);
    por_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    por_n = 1'b0; sys_rst_n = 1'b0; core_halted = 1'b0;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_be = 4'h0; reg_wdata = 32'h0;
    idle(2);
    por_n = 1'b1;
    idle(1);
    t_reset;
    sys_rst_n = 1'b1;
    t_cfg_layout;
    t_partial;
    t_frz_layout;
    t_idle;
    t_timer;
    t_wdg;
    t_holds;
    t_sysrst;
    t_por;
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule